// File: doc/BRIEF.md
# Rotate and Mask Unit

This block is the rotate-and-mask datapath of a 64-bit integer execution pipe. It rotates a source operand to the left and then either clears every bit outside a generated mask or merges the rotated value into a second operand (the insert target) under that mask. The shift count comes from an immediate field or from the low bits of a shift register operand. A 3-bit operation code selects one of six variants: two word forms and four doubleword forms.

Masks use big-endian bit numbering. Bit index 0 is the most significant bit of the 64-bit value, and index 63 is the least significant. A mask is described by a begin index and an end index. When begin is at most end, the ones run from begin through end. When begin is greater than end, the ones wrap around. The word forms rotate only the low 32 bits and copy the result into both halves. Their 5-bit begin and end fields then address the low word, offset by 32. The unit is purely combinational and holds no state. Decode, the register file and any flag recording sit outside it.

Top module: `rotmask_unit`

## Requirements
- R1: With begin ≤ end, the mask has a one at every big-endian index from begin through end inclusive and a zero elsewhere. Index i is vector bit 63−i.
- R2: With begin > end, the mask is all ones except at the indices end+1 through begin−1.
- R3: With op_i = 2 (doubleword left-clear), res_o equals rotl64(src_i, n) AND mask(mb_i, 63).
- R4: With op_i = 3 (doubleword right-clear), res_o equals rotl64(src_i, n) AND mask(0, me_i).
- R5: With op_i = 4 (doubleword clear), res_o equals rotl64(src_i, n) AND mask(mb_i, 63−n). The value 63−n is the bitwise complement of the 6-bit count n.
- R6: With op_i = 5 (doubleword insert), res_o equals (rotl64(src_i, n) AND m) OR (ins_i AND NOT m), where m = mask(mb_i, 63−n).
- R7: The count n is sh_imm_i when sh_use_reg_i = 0 and sh_reg_i when sh_use_reg_i = 1. Doubleword forms use all 6 bits of the selected count. Word forms use only its low 5 bits.
- R8: A count of zero leaves the source unrotated before the mask is applied.
- R9: With op_i = 0 (word clear), the low 32 bits of src_i are rotated left by the 5-bit count. The 32-bit result r is replicated as {r, r}. res_o equals {r, r} AND mask(32+mb_i[4:0], 32+me_i[4:0]).
- R10: With op_i = 1 (word insert), res_o equals ({r, r} AND m) OR (ins_i AND NOT m), using the word mask of R9.
- R11: The op_i codes 6 and 7 are reserved and drive res_o to zero.
- R12: res_o is a combinational function of the present inputs only, with no clocked state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Source operand to be rotated |
| ins_i | input | 64 | Insert target kept outside the mask by insert variants |
| sh_imm_i | input | 6 | Immediate rotate count |
| sh_reg_i | input | 6 | Low bits of the register-supplied rotate count |
| sh_use_reg_i | input | 1 | 1 selects sh_reg_i, 0 selects sh_imm_i |
| mb_i | input | 6 | Mask begin index, big-endian |
| me_i | input | 6 | Mask end index, big-endian |
| op_i | input | 3 | Operation code (0 word clear, 1 word insert, 2 left-clear, 3 right-clear, 4 clear, 5 insert, 6–7 reserved) |
| res_o | output | 64 | Rotated and masked result |

## Verification
Every result is due in the same cycle as its stimulus: no register lies between any input and res_o. The bench therefore changes inputs on the falling clock edge and samples res_o 2 ns later, before the next rising edge. The sweep walks every begin/end pair for each of the eight operation codes, changing the data, the count and the count source on each step. This covers the non-wrapping mask, the wrapping mask and the complemented-count end index. Directed cases cover a zero count, register counts whose bit 5 is set on word forms, and the reserved codes.

// File: rtl/rotmask_pkg.sv
// Shared constants and operation codes of the rotate-and-mask unit.
// Assumes a power-of-two data width of at least 8 bits.
package rotmask_pkg;
    parameter int XLEN = 64;
    localparam int HLEN = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);
    localparam int HSHW = $clog2(HLEN);

    typedef enum logic [2:0] {
        OP_W_CLR   = 3'd0,
        OP_W_INS   = 3'd1,
        OP_D_LCLR  = 3'd2,
        OP_D_RCLR  = 3'd3,
        OP_D_CLR   = 3'd4,
        OP_D_INS   = 3'd5,
        OP_RSVD6   = 3'd6,
        OP_RSVD7   = 3'd7
    } rm_op_e;
endpackage

// File: rtl/rotmask_rotl.sv
// Left rotator of parameterized width.
// Assumes amt_i < W; output is combinational.
module rotmask_rotl #(
    parameter int W  = 64,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  data_o
);
    logic [2*W-1:0] dbl;

    // Rotate by shifting a doubled copy and keeping the upper half.
    always_comb begin
        dbl    = {data_i, data_i} << amt_i;
        data_o = dbl[2*W-1:W];
        // R8
        zero_rot_chk: assert ((amt_i != '0) || (data_o == data_i));
    end
endmodule

// File: rtl/rotmask_maskgen.sv
// Mask generator with big-endian indices: index 0 is the MSB.
// Ones from begin to end; wraps when begin exceeds end.
module rotmask_maskgen #(
    parameter int W  = 64,
    localparam int AW = $clog2(W)
) (
    input  logic [AW-1:0] beg_i,
    input  logic [AW-1:0] end_i,
    output logic [W-1:0]  mask_o
);
    // Build each mask bit from its big-endian index and check the popcount.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (beg_i <= end_i)
                mask_o[W-1-i] = (i >= int'(beg_i)) && (i <= int'(end_i));
            else
                mask_o[W-1-i] = (i >= int'(beg_i)) || (i <= int'(end_i));
        end
        // R1
        mask_span_chk: assert ((beg_i > end_i) ||
            ($countones(mask_o) == int'(end_i) - int'(beg_i) + 1));
        // R2
        mask_wrap_chk: assert ((beg_i <= end_i) ||
            ($countones(mask_o) == W - (int'(beg_i) - int'(end_i) - 1)));
    end
endmodule

// File: rtl/rotmask_unit.sv
// Rotate-and-mask unit: word and doubleword rotate, then clear or insert
// under a generated mask. Purely combinational; no clock or reset.
// Assumes op_i is stable for the cycle; reserved codes yield zero.
module rotmask_unit
    import rotmask_pkg::*;
(
    input  logic [XLEN-1:0] src_i,
    input  logic [XLEN-1:0] ins_i,
    input  logic [SHW-1:0]  sh_imm_i,
    input  logic [SHW-1:0]  sh_reg_i,
    input  logic            sh_use_reg_i,
    input  logic [SHW-1:0]  mb_i,
    input  logic [SHW-1:0]  me_i,
    input  logic [2:0]      op_i,
    output logic [XLEN-1:0] res_o
);
    logic [SHW-1:0]  dsh;
    logic [HSHW-1:0] wsh;
    logic [HLEN-1:0] wrot_half;
    logic [XLEN-1:0] wrot;
    logic [XLEN-1:0] drot;
    logic [SHW-1:0]  mbeg;
    logic [SHW-1:0]  mend;
    logic [XLEN-1:0] mask;
    rm_op_e          op;

    // Pick the rotate count source and its word-form truncation.
    always_comb begin
        dsh = sh_use_reg_i ? sh_reg_i : sh_imm_i;
        wsh = dsh[HSHW-1:0];
        op  = rm_op_e'(op_i);
    end

    rotmask_rotl #(.W(HLEN)) i_rot_word (
        .data_i (src_i[HLEN-1:0]),
        .amt_i  (wsh),
        .data_o (wrot_half)
    );

    rotmask_rotl #(.W(XLEN)) i_rot_dword (
        .data_i (src_i),
        .amt_i  (dsh),
        .data_o (drot)
    );

    // Replicate the rotated word into both halves.
    always_comb wrot = {wrot_half, wrot_half};

    // Derive the mask begin and end indices for each variant.
    always_comb begin
        unique case (op)
            OP_W_CLR, OP_W_INS: begin
                mbeg = {1'b1, mb_i[HSHW-1:0]};
                mend = {1'b1, me_i[HSHW-1:0]};
            end
            OP_D_LCLR: begin
                mbeg = mb_i;
                mend = '1;
            end
            OP_D_RCLR: begin
                mbeg = '0;
                mend = me_i;
            end
            default: begin
                mbeg = mb_i;
                mend = ~dsh;
            end
        endcase
    end

    rotmask_maskgen #(.W(XLEN)) i_maskgen (
        .beg_i  (mbeg),
        .end_i  (mend),
        .mask_o (mask)
    );

    // Apply the mask, either clearing or merging into the insert target.
    always_comb begin
        unique case (op)
            OP_W_CLR:                       res_o = wrot & mask;
            OP_W_INS:                       res_o = (wrot & mask) | (ins_i & ~mask);
            OP_D_LCLR, OP_D_RCLR, OP_D_CLR: res_o = drot & mask;
            OP_D_INS:                       res_o = (drot & mask) | (ins_i & ~mask);
            default:                        res_o = '0;
        endcase
        // R6
        insert_keep_chk: assert (!((op == OP_W_INS) || (op == OP_D_INS)) ||
            (((res_o ^ ins_i) & ~mask) == '0));
        // R9
        word_upper_zero_chk: assert (!((op == OP_W_CLR) &&
            (mb_i[HSHW-1:0] <= me_i[HSHW-1:0])) || (res_o[XLEN-1:HLEN] == '0));
    end
endmodule

// File: tb/test_rotmask_unit.sv
module test_rotmask_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src, ins, res;
    logic [5:0]  sh_imm, sh_reg, mb, me;
    logic        use_reg;
    logic [2:0]  op;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    rotmask_unit i_rotmask_unit (
        .src_i(src), .ins_i(ins), .sh_imm_i(sh_imm), .sh_reg_i(sh_reg),
        .sh_use_reg_i(use_reg), .mb_i(mb), .me_i(me), .op_i(op), .res_o(res)
    );

    function automatic logic [63:0] ref_mask(int b, int e);
        logic [63:0] m;
        for (int i = 0; i < 64; i++)
            m[63-i] = (b <= e) ? (i >= b && i <= e) : (i >= b || i <= e);
        return m;
    endfunction

    function automatic logic [63:0] ref_rotl(logic [63:0] x, int n, int w);
        logic [63:0] r = '0;
        for (int j = 0; j < w; j++) r[(j + n) % w] = x[j];
        return r;
    endfunction

    function automatic logic [63:0] ref_res(logic [2:0] o, logic [63:0] s,
            logic [63:0] t, int n, int b, int e);
        logic [63:0] w, d, m;
        w = ref_rotl(s, n % 32, 32);
        w = {w[31:0], w[31:0]};
        d = ref_rotl(s, n, 64);
        case (o)
            3'd0: return w & ref_mask(32 + b % 32, 32 + e % 32);
            3'd1: begin m = ref_mask(32 + b % 32, 32 + e % 32); return (w & m) | (t & ~m); end
            3'd2: return d & ref_mask(b, 63);
            3'd3: return d & ref_mask(0, e);
            3'd4: return d & ref_mask(b, 63 - n);
            3'd5: begin m = ref_mask(b, 63 - n); return (d & m) | (t & ~m); end
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] o, int b, int e);
        case (o)
            3'd0: return (b % 32 <= e % 32) ? "R9/R1" : "R9/R2";
            3'd1: return "R10";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return (b <= 63 - e) ? "R5/R1" : "R5/R2";
            3'd5: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic apply_check(logic [2:0] o, logic [63:0] s, logic [63:0] t,
            logic [5:0] si, logic [5:0] sr, logic ur, logic [5:0] b, logic [5:0] e,
            string tag);
        logic [63:0] exp;
        int n;
        @(negedge clk);
        op = o; src = s; ins = t; sh_imm = si; sh_reg = sr; use_reg = ur; mb = b; me = e;
        n = ur ? int'(sr) : int'(si);
        exp = ref_res(o, s, t, n, int'(b), int'(e));
        #2;
        n_chk++;
        if (res !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d mb=%0d me=%0d n=%0d got=%h exp=%h",
                     tag, o, b, e, n, res, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        src = '0; ins = '0; sh_imm = '0; sh_reg = '0; use_reg = 1'b0;
        mb = '0; me = '0; op = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R12: all-zero inputs give zero output with no clocked state
        @(negedge clk); #2;
        n_chk++;
        if (res !== 64'd0) begin
            n_fail++;
            $display("FAIL R12 idle got=%h exp=%h", res, 64'd0);
        end
        // R8: zero count passes source unrotated
        apply_check(3'd2, 64'h0123_4567_89AB_CDEF, 64'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, "R8");
        apply_check(3'd0, 64'hFFFF_0000_8765_4321, 64'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd31, "R8");
        // R7: register count selected; bit 5 ignored by word forms
        apply_check(3'd0, 64'h0000_0000_8000_0001, 64'd0, 6'd3, 6'd33, 1'b1, 6'd0, 6'd31, "R7");
        apply_check(3'd2, 64'h8000_0000_0000_0001, 64'd0, 6'd1, 6'd40, 1'b1, 6'd0, 6'd63, "R7");
        apply_check(3'd5, 64'hDEAD_BEEF_0BAD_F00D, 64'h5555_AAAA_5555_AAAA, 6'd9, 6'd63, 1'b1, 6'd0, 6'd0, "R7");
        // R11: reserved codes
        apply_check(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd5, 6'd0, 1'b0, 6'd0, 6'd63, "R11");
        apply_check(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd5, 6'd0, 1'b0, 6'd9, 6'd3, "R11");
        // Exhaustive begin/end sweep for every operation code
        for (int o = 0; o < 8; o++) begin
            for (int b = 0; b < 64; b++) begin
                for (int e = 0; e < 64; e++) begin
                    logic [5:0] si, sr;
                    logic [63:0] s, t;
                    lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
                    s  = lfsr;
                    t  = ~{lfsr[31:0], lfsr[63:32]};
                    si = 6'((b * 7 + e * 3 + o) % 64);
                    sr = 6'((b * 5 + e * 11) % 64);
                    apply_check(3'(o), s, t, si, sr, ((b + e) % 2) == 1,
                                6'(b), 6'(e),
                                tag_of(3'(o), b, (o == 4) ? int'(((b + e) % 2 == 1) ? sr : si) : e));
                end
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule